// File: doc/BRIEF.md
# PHY bring-up sequencer

This controller takes an Ethernet PHY from an unknown state to a negotiated link by issuing management-register transactions to an attached serial management master. A one-cycle `start` pulse, accepted only while the sequencer is idle, launches the run. The sequencer soft-resets the PHY and polls the control register until the self-clearing reset bit drops. It then masks the PHY interrupt sources, writes the capability advertisement and restarts autonegotiation. After that it polls the status register until negotiation reports completion.

Each transaction is a single request held on `req_*` until the master answers with a one-cycle `req_ack`. For reads, the returned word is valid on `rsp_rdata` in the same cycle as the acknowledge. Both polling loops have a bounded retry count, and a wait counter spaces successive polls. If a status read shows a remote fault while negotiation is still pending, the sequencer issues a fresh restart with speed and duplex forced, then keeps polling. The run ends with exactly one of three sticky outcome flags: done, reset-timeout or negotiation-timeout.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset, `busy`, `req_valid` and all three outcome flags are 0.
- R2: The first request after an accepted start is a write to register 0 with data 16'h8000, which sets the reset bit (bit 15) and clears every other bit.
- R3: Register 0 is read until bit 15 reads 0. At most `RST_POLLS` reads are made, and successive reads are separated by at least `RST_GAP` idle cycles.
- R4: If bit 15 is still set on read number `RST_POLLS`, `rst_timeout` rises, the sequencer returns to idle and no further request is issued.
- R5: Once reset clears, the next write goes to register 18 with data `IMASK_VAL` (default 16'hFF80, bits 15:7 masking the link-fail, sync-loss, codeword, start-delimiter, end-delimiter, polarity, jabber, speed-detect and duplex-detect sources). The write after it goes to register 4 with `ADV_VAL` (default 16'h01E1: 100 full, 100 half, 10 full and 10 half duplex, plus selector 00001).
- R6: The next write is to register 0 with 16'h1200, which sets autonegotiation enable (bit 12) and restart (bit 9).
- R7: Register 1 is then read up to `AN_POLLS` times with at least `AN_GAP` cycles between reads. A read with bit 5 set raises `done` and returns the sequencer to idle.
- R8: If a status read has bit 5 clear and bit 4 (remote fault) set, and polls remain, the next request is a write to register 0 with 16'h3300 (enable, restart, speed bit 13, duplex bit 8). Polling then resumes.
- R9: If read number `AN_POLLS` still has bit 5 clear, `neg_timeout` rises and the sequencer returns to idle without a fault write.
- R10: Register, direction and write data stay stable while `req_valid` waits for `req_ack`.
- R11: A start pulse while busy has no effect. An accepted start clears all outcome flags, the flags otherwise hold their value, and at most one flag is set at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the bring-up sequence (accepted when idle) |
| req_valid | output | 1 | Management transaction requested |
| req_write | output | 1 | 1 = write, 0 = read |
| req_reg | output | 5 | PHY register number |
| req_wdata | output | 16 | Write data |
| req_ack | input | 1 | One-cycle completion from the management master |
| rsp_rdata | input | 16 | Read data, valid with `req_ack` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Negotiation completed (sticky) |
| rst_timeout | output | 1 | PHY reset never cleared (sticky) |
| neg_timeout | output | 1 | Negotiation never completed (sticky) |

## Verification
The bench keeps the default retry limits of 6 and 20, so the real boundaries are hit exactly: reset clearing on the last allowed poll, and failing one poll later. Negotiation is likewise exercised finishing on poll 20 and timing out at 20. It shrinks the poll intervals to 3 and 5 cycles. With those intervals a full 20-poll run fits in a few hundred cycles, and the spacing between reads can still be measured against the interval. A remote fault is injected both mid-run and on the final poll, where no restart write may follow.

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq #(
  parameter int          RST_POLLS = 6,
  parameter int          AN_POLLS  = 20,
  parameter int          RST_GAP   = 64,
  parameter int          AN_GAP    = 1024,
  parameter logic [15:0] IMASK_VAL = 16'hFF80,
  parameter logic [15:0] ADV_VAL   = 16'h01E1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        req_valid,
  output logic        req_write,
  output logic [4:0]  req_reg,
  output logic [15:0] req_wdata,
  input  logic        req_ack,
  input  logic [15:0] rsp_rdata,
  output logic        busy,
  output logic        done,
  output logic        rst_timeout,
  output logic        neg_timeout
);
  localparam int MAXGAP  = (RST_GAP > AN_GAP) ? RST_GAP : AN_GAP;
  localparam int MAXPOLL = (RST_POLLS > AN_POLLS) ? RST_POLLS : AN_POLLS;
  localparam int GW = $clog2(MAXGAP + 1);
  localparam int PW = $clog2(MAXPOLL + 1);
  localparam logic [4:0]  REG_CTRL  = 5'd0;
  localparam logic [4:0]  REG_STAT  = 5'd1;
  localparam logic [4:0]  REG_ADV   = 5'd4;
  localparam logic [4:0]  REG_IMASK = 5'd18;
  localparam logic [15:0] CTRL_RST   = 16'h8000;
  localparam logic [15:0] CTRL_AN    = 16'h1200;
  localparam logic [15:0] CTRL_FAULT = 16'h3300;

  typedef enum logic [3:0] {
    S_IDLE, S_RWR, S_RRD, S_RWT, S_MWR, S_AWR, S_NWR, S_SRD, S_SWT, S_FWR
  } st_t;

  st_t           st;
  logic [GW-1:0] gap;
  logic [PW-1:0] polls;
  logic [PW-1:0] polls_nx;

  assign busy     = (st != S_IDLE);
  assign polls_nx = polls + 1'b1;

  always_comb begin
    req_valid = 1'b1;
    req_write = 1'b1;
    req_reg   = REG_CTRL;
    req_wdata = 16'h0000;
    unique case (st)
      S_RWR:   req_wdata = CTRL_RST;
      S_RRD:   req_write = 1'b0;
      S_MWR: begin req_reg = REG_IMASK; req_wdata = IMASK_VAL; end
      S_AWR: begin req_reg = REG_ADV;   req_wdata = ADV_VAL;   end
      S_NWR:   req_wdata = CTRL_AN;
      S_FWR:   req_wdata = CTRL_FAULT;
      S_SRD: begin req_write = 1'b0; req_reg = REG_STAT; end
      default: begin req_valid = 1'b0; req_write = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; gap <= '0; polls <= '0;
      done <= 1'b0; rst_timeout <= 1'b0; neg_timeout <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          done <= 1'b0; rst_timeout <= 1'b0; neg_timeout <= 1'b0;
          polls <= '0; st <= S_RWR;
        end
        S_RWR: if (req_ack) st <= S_RRD;
        S_RRD: if (req_ack) begin
          polls <= polls_nx;
          if (!rsp_rdata[15]) st <= S_MWR;
          else if (polls_nx == PW'(RST_POLLS)) begin rst_timeout <= 1'b1; st <= S_IDLE; end
          else begin gap <= GW'(RST_GAP - 1); st <= S_RWT; end
        end
        S_RWT: if (gap == '0) st <= S_RRD; else gap <= gap - 1'b1;
        S_MWR: if (req_ack) st <= S_AWR;
        S_AWR: if (req_ack) st <= S_NWR;
        S_NWR: if (req_ack) begin polls <= '0; st <= S_SRD; end
        S_SRD: if (req_ack) begin
          polls <= polls_nx;
          if (rsp_rdata[5]) begin done <= 1'b1; st <= S_IDLE; end
          else if (polls_nx == PW'(AN_POLLS)) begin neg_timeout <= 1'b1; st <= S_IDLE; end
          else if (rsp_rdata[4]) st <= S_FWR;
          else begin gap <= GW'(AN_GAP - 1); st <= S_SWT; end
        end
        S_FWR: if (req_ack) begin gap <= GW'(AN_GAP - 1); st <= S_SWT; end
        S_SWT: if (gap == '0) st <= S_SRD; else gap <= gap - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ack) |=> (req_valid && $stable(req_reg) && $stable(req_wdata) && $stable(req_write))) // R10
    else $error("request changed before acknowledge");

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, rst_timeout, neg_timeout})) // R11
    else $error("more than one outcome flag");

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done) // R11
    else $error("done flag dropped");

  AST_RST_TIMEOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_timeout |-> !req_valid) // R4
    else $error("request after reset timeout");

  AST_RST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_timeout) |-> (polls == PW'(RST_POLLS))) // R3
    else $error("reset poll count wrong at timeout");

  AST_AN_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(neg_timeout) |-> (polls == PW'(AN_POLLS))) // R9
    else $error("status poll count wrong at timeout");
endmodule

// File: tb/phy_bringup_seq_tb_top.sv
module phy_bringup_seq_tb_top;
  localparam int RG = 3;
  localparam int AG = 5;
  localparam int RP = 6;
  localparam int AP = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic req_ack = 1'b0;
  logic [15:0] rsp_rdata = 16'h0;
  logic req_valid, req_write, busy, done, rst_timeout, neg_timeout;
  logic [4:0] req_reg;
  logic [15:0] req_wdata;

  always #5 clk = ~clk;

  phy_bringup_seq #(.RST_POLLS(RP), .AN_POLLS(AP), .RST_GAP(RG), .AN_GAP(AG)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid), .req_write(req_write),
    .req_reg(req_reg), .req_wdata(req_wdata), .req_ack(req_ack), .rsp_rdata(rsp_rdata),
    .busy(busy), .done(done), .rst_timeout(rst_timeout), .neg_timeout(neg_timeout));

  // res: 1 done, 2 reset timeout, 3 negotiation timeout
  typedef struct packed { int rb; int ab; int fa; int res; int nw; int nc; int ns; } vec_t;
  localparam vec_t VECS [7] = '{
    '{0, 0, 0, 1, 4, 1, 1},
    '{5, 2, 0, 1, 4, 6, 3},
    '{6, 0, 0, 2, 1, 6, 0},
    '{0, 19, 0, 1, 4, 1, 20},
    '{1, 20, 0, 3, 4, 2, 20},
    '{0, 3, 2, 1, 5, 1, 4},
    '{0, 25, 20, 3, 4, 1, 20}
  };

  int checks = 0, fails = 0;
  int m_rb = 0, m_ab = 0, m_fa = 0;
  int ncr = 0, nsr = 0, nw = 0, lat = 0, cyc = 0;
  int last_c = -1, last_s = -1, min_c = 1000000, min_s = 1000000;
  logic [4:0]  w_reg [8];
  logic [15:0] w_dat [8];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // PHY management responder: acknowledges every request after two cycles
  always @(negedge clk) begin
    cyc++;
    req_ack = 1'b0;
    if (req_valid && !req_ack_q) begin
      if (lat == 1) begin
        lat = 0;
        req_ack = 1'b1;
        if (req_write) begin
          if (nw < 8) begin w_reg[nw] = req_reg; w_dat[nw] = req_wdata; end
          nw++;
        end else if (req_reg == 5'd0) begin
          ncr++;
          if (last_c >= 0 && cyc - last_c < min_c) min_c = cyc - last_c;
          last_c = cyc;
          rsp_rdata = (ncr <= m_rb) ? 16'h8000 : 16'h0000;
        end else begin
          nsr++;
          if (last_s >= 0 && cyc - last_s < min_s) min_s = cyc - last_s;
          last_s = cyc;
          rsp_rdata = 16'h0000;
          if (nsr > m_ab) rsp_rdata[5] = 1'b1;
          if (nsr == m_fa) rsp_rdata[4] = 1'b1;
        end
      end else lat++;
    end
    req_ack_q = req_ack;
  end
  logic req_ack_q = 1'b0;

  task automatic run(input vec_t v, input bit poke);
    m_rb = v.rb; m_ab = v.ab; m_fa = v.fa;
    ncr = 0; nsr = 0; nw = 0; last_c = -1; last_s = -1; min_c = 1000000; min_s = 1000000;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && !done && !rst_timeout && !neg_timeout, "R11 flags cleared on start",
        {busy, done, rst_timeout, neg_timeout}, 4'b1000);
    if (poke) begin
      repeat (30) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    if (busy) chk(1'b0, "watchdog busy", 1, 0);
    repeat (20) @(negedge clk);
    chk(done == (v.res == 1), "R7 done flag", done, v.res == 1);
    chk(rst_timeout == (v.res == 2), "R4 reset timeout flag", rst_timeout, v.res == 2);
    chk(neg_timeout == (v.res == 3), "R9 negotiation timeout flag", neg_timeout, v.res == 3);
    chk(nw == v.nw, "R4 R8 R9 write count", nw, v.nw);
    chk(ncr == v.nc, "R3 control reads", ncr, v.nc);
    chk(nsr == v.ns, "R7 status reads", nsr, v.ns);
    chk(w_reg[0] == 5'd0 && w_dat[0] == 16'h8000, "R2 first write", {w_reg[0], w_dat[0]}, 21'h08000);
    if (v.nw >= 4) begin
      chk(w_reg[1] == 5'd18 && w_dat[1] == 16'hFF80, "R5 mask write", {w_reg[1], w_dat[1]}, {5'd18, 16'hFF80});
      chk(w_reg[2] == 5'd4 && w_dat[2] == 16'h01E1, "R5 advert write", {w_reg[2], w_dat[2]}, {5'd4, 16'h01E1});
      chk(w_reg[3] == 5'd0 && w_dat[3] == 16'h1200, "R6 restart write", {w_reg[3], w_dat[3]}, 21'h01200);
    end
    if (v.nw == 5)
      chk(w_reg[4] == 5'd0 && w_dat[4] == 16'h3300, "R8 fault restart", {w_reg[4], w_dat[4]}, 21'h03300);
    if (v.nc >= 2) chk(min_c >= RG + 1, "R3 reset poll spacing", min_c, RG + 1);
    if (v.ns >= 2) chk(min_s >= AG + 1, "R7 status poll spacing", min_s, AG + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !req_valid && !done && !rst_timeout && !neg_timeout, "R1 reset state",
        {busy, req_valid, done, rst_timeout, neg_timeout}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !req_valid, "R1 idle after reset", {busy, req_valid}, 0);
    for (int k = 0; k < 7; k++) run(VECS[k], 1'b0);
    // R10 handshake hold and R11 start while busy ignored
    run(VECS[3], 1'b1);
    chk(ncr == 1 && nw == 4, "R11 start ignored while busy", {ncr[7:0], nw[7:0]}, 16'h0104);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2ms;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule